// File: doc/BRIEF.md
# Dual Compare-Match Output Controller

This block holds a free-running up-counter and two compare registers, A and B. Together they drive a single timer output pin. Each compare channel has its own 2-bit action selector. When the counter reaches a channel's compare value, that channel's action is applied to the pin level: keep it, force it low, force it high, or toggle it. The block also produces an output-enable signal. When neither channel is set to change the pin, the output-enable is dropped, which asks the surrounding pad logic for high impedance.

Software, or a neighbouring block, uses a plain register port to program the two compare values and a control byte that holds both selectors. The same port can read the live count. The interface has no stream data, so every pin is a plain control or status signal. A write takes effect at the clock edge where `wr_en` is high. The read data is a combinational decode of `addr`.

Top module: `cmp_pin_ctrl`

## Requirements
- R1: After reset the counter is 0. On each clock edge with `cnt_en` high it increments by one, wrapping from 255 to 0. With `cnt_en` low it holds its value.
- R2: A selector value applies an action to the pin level at the clock edge that ends the matching cycle. The codes are: 00 keeps the level, 01 makes it 0, 10 makes it 1, 11 inverts it.
- R3: A match event on a channel occurs in a cycle where `cnt_en` is high and the count equals that channel's compare value. The level changes only on match events.
- R4: When both channels have a match event in the same cycle and channel B's selector is not 00, channel B's action decides the new level. If channel B's selector is 00, channel A's action applies.
- R5: `pin_oe` is 0 exactly when both selectors are 00, and 1 otherwise.
- R6: After reset the pin level is 0, and it stays 0 until the first match event whose selector is not 00.
- R7: The control byte is at address 2. Bits 1:0 are selector A and bits 3:2 are selector B, and both reset to 00. On readback, bit 4 reads 0 and bits 7:5 read 1. Written values in bits 7:4 have no effect.
- R8: Compare A is at address 0 and compare B is at address 1. Both reset to 255 and read back the last value written. A new value is used for matching from the cycle after the write.
- R9: Address 3 reads the current count. Writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count enable; also qualifies match events |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 compare A, 1 compare B, 2 control, 3 count) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pin_out | output | 1 | Pin level |
| pin_oe | output | 1 | Output enable; 0 requests high impedance |

## Verification
Directed sequences isolate single behaviours. One sets a compare value, lets the counter reach it, and checks that the level moves one edge later. Another sets both compares to the same value under every pair of selectors, which separates B-over-A priority from plain last-writer effects. Toggle selectors with `cnt_en` gated off show that a standing equality is not a match. Long runs of random enables, compare values and selector writes, compared cycle by cycle against a bench model, expose errors in the timing of compare-register and selector updates relative to match events.

// File: rtl/cmp_pin_pkg.sv
package cmp_pin_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  localparam logic [1:0] ADR_CMP_A = 2'd0;
  localparam logic [1:0] ADR_CMP_B = 2'd1;
  localparam logic [1:0] ADR_CTRL  = 2'd2;
  localparam logic [1:0] ADR_COUNT = 2'd3;

  function automatic logic apply_act(input act_e a, input logic cur);
    case (a)
      ACT_LOW:    apply_act = 1'b0;
      ACT_HIGH:   apply_act = 1'b1;
      ACT_TOGGLE: apply_act = ~cur;
      default:    apply_act = cur;
    endcase
  endfunction
endpackage

// File: rtl/cmp_pin_counter.sv
module cmp_pin_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt + 1'b1;
  end

  // R1: wrap from the top value to zero
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt == CNT_MAX) |=> (cnt == '0));
  // R1: hold while disabled
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt));
endmodule

// File: rtl/cmp_pin_regs.sv
module cmp_pin_regs
  import cmp_pin_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NUM_CH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [1:0]                   addr,
  input  logic [7:0]                   wdata,
  input  logic [CNT_W-1:0]             cnt,
  output logic [NUM_CH-1:0][CNT_W-1:0] cmp,
  output act_e [NUM_CH-1:0]            sel,
  output logic [7:0]                   rdata
);
  localparam logic [CNT_W-1:0] CMP_RST = {CNT_W{1'b1}};

  // one compare register per channel, addressed by channel index
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp[ch] <= CMP_RST;
      else if (wr_en && addr == 2'(ch)) cmp[ch] <= wdata[CNT_W-1:0];
    end
  end

  // selectors: channel n occupies control bits 2n+1:2n
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel[ch] <= ACT_KEEP;
      else if (wr_en && addr == ADR_CTRL) sel[ch] <= act_e'(wdata[2*ch +: 2]);
    end
  end

  logic [7:0] ctrl_rd;
  always_comb begin
    ctrl_rd = 8'b1110_0000;
    for (int ch = 0; ch < NUM_CH; ch++) ctrl_rd[2*ch +: 2] = sel[ch];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_CMP_A: rdata[CNT_W-1:0] = cmp[0];
      ADR_CMP_B: rdata[CNT_W-1:0] = cmp[1];
      ADR_CTRL:  rdata = ctrl_rd;
      default:   rdata[CNT_W-1:0] = cnt;
    endcase
  end

  // R7: reserved readback pattern
  a_r7_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADR_CTRL) |-> (rdata[7:4] == 4'b1110));
  // R8: a compare write lands in the addressed register
  a_r8_cmp_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_CMP_A) |=> (cmp[0] == $past(wdata[CNT_W-1:0])));
endmodule

// File: rtl/cmp_pin_match.sv
module cmp_pin_match #(
  parameter int CNT_W  = 8,
  parameter int NUM_CH = 2
) (
  input  logic                         cnt_en,
  input  logic [CNT_W-1:0]             cnt,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cmp,
  output logic [NUM_CH-1:0]            ev
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_eq
    assign ev[ch] = cnt_en && (cnt == cmp[ch]);
  end
endmodule

// File: rtl/cmp_pin_level.sv
module cmp_pin_level
  import cmp_pin_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ev,
  input  act_e [NUM_CH-1:0] sel,
  output logic              level
);
  logic level_nx;

  // higher channel index wins when its action is not keep
  always_comb begin
    level_nx = level;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (ev[ch] && sel[ch] != ACT_KEEP) level_nx = apply_act(sel[ch], level);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= 1'b0;
    else        level <= level_nx;
  end

  // R3: no event, no change
  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == '0) |=> $stable(level));
  // R4: channel B forcing low overrides anything on A
  a_r4_b_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[NUM_CH-1] && sel[NUM_CH-1] == ACT_LOW) |=> !level);
  // R2: toggle with a lone event inverts
  a_r2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == 2'b01 && sel[0] == ACT_TOGGLE) |=> (level != $past(level)));
endmodule

// File: rtl/cmp_pin_ctrl.sv
module cmp_pin_ctrl
  import cmp_pin_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_en,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       pin_out,
  output logic       pin_oe
);
  localparam int NUM_CH = 2;

  logic [CNT_W-1:0]             cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp;
  act_e [NUM_CH-1:0]            sel;
  logic [NUM_CH-1:0]            ev;
  logic                         any_drive;

  cmp_pin_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt(cnt));

  cmp_pin_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt(cnt), .cmp(cmp), .sel(sel), .rdata(rdata));

  cmp_pin_match #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_match (
    .cnt_en(cnt_en), .cnt(cnt), .cmp(cmp), .ev(ev));

  cmp_pin_level #(.NUM_CH(NUM_CH)) u_lvl (
    .clk(clk), .rst_n(rst_n), .ev(ev), .sel(sel), .level(pin_out));

  always_comb begin
    any_drive = 1'b0;
    for (int ch = 0; ch < NUM_CH; ch++) any_drive |= (sel[ch] != ACT_KEEP);
  end
  assign pin_oe = any_drive;

  // R5: a readback of an all-keep control byte means the pin is released
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADR_CTRL && rdata[3:0] == 4'b0000) |-> !pin_oe);
endmodule

// File: tb/sim_cmp_pin_ctrl.sv
`timescale 1ns/100ps
module sim_cmp_pin_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic pin_out, pin_oe;
  int checks = 0, errors = 0;

  // bench model
  logic [7:0] m_cnt, m_ca, m_cb;
  logic [1:0] m_sa, m_sb;
  logic m_lvl;

  always #2.5 clk = ~clk;

  cmp_pin_ctrl u0 (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe));

  function automatic logic act(input logic [1:0] s, input logic cur);
    case (s)
      2'b01: act = 1'b0;
      2'b10: act = 1'b1;
      2'b11: act = ~cur;
      default: act = cur;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 8'd0; m_ca = 8'hFF; m_cb = 8'hFF; m_sa = 2'b00; m_sb = 2'b00; m_lvl = 1'b0;
  endtask

  // one clock: drive at negedge, update model, check at next negedge
  task automatic cyc(input logic en, input logic we, input logic [1:0] a, input logic [7:0] d);
    logic ea, eb, nl;
    cnt_en = en; wr_en = we; addr = a; wdata = d;
    ea = en && (m_cnt == m_ca);
    eb = en && (m_cnt == m_cb);
    nl = m_lvl;
    if (ea && m_sa != 2'b00) nl = act(m_sa, m_lvl);
    if (eb && m_sb != 2'b00) nl = act(m_sb, m_lvl);
    @(negedge clk);
    m_lvl = nl;
    if (en) m_cnt = m_cnt + 8'd1;
    if (we) begin
      case (a)
        2'd0: m_ca = d;
        2'd1: m_cb = d;
        2'd2: begin m_sa = d[1:0]; m_sb = d[3:2]; end
        default: ;
      endcase
    end
    wr_en = 1'b0;
  endtask

  task automatic chk_pin(input string req);
    chk(req, {31'd0, pin_out}, {31'd0, m_lvl});
    chk("R5", {31'd0, pin_oe}, {31'd0, (m_sa != 2'b00) || (m_sb != 2'b00)});
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr = a; #0.5;
    chk(req, {24'd0, rdata}, {24'd0, exp});
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] ctl;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk_pin("R6");
    rd("R1", 2'd3, 8'd0);
    rd("R8", 2'd0, 8'hFF);
    rd("R8", 2'd1, 8'hFF);
    rd("R7", 2'd2, 8'hE0);

    // R7: upper control bits ignored, layout readback
    cyc(1'b0, 1'b1, 2'd2, 8'hF6);
    rd("R7", 2'd2, 8'hE6);
    chk_pin("R5");
    // R9: writes to count ignored
    cyc(1'b0, 1'b1, 2'd3, 8'h55);
    rd("R9", 2'd3, 8'd0);
    // R6: level low while selects nonzero and no match yet
    cyc(1'b1, 1'b1, 2'd0, 8'd10);
    rd("R8", 2'd0, 8'd10);
    for (int i = 0; i < 8; i++) begin cyc(1'b1, 1'b0, 2'd0, 8'd0); chk_pin("R6"); end
    // R2/R3: A high at 10 (sel A=10) -> high one edge after count 10
    cyc(1'b0, 1'b1, 2'd2, 8'h02);
    while (m_cnt != 8'd10) begin cyc(1'b1, 1'b0, 2'd0, 8'd0); chk_pin("R2"); end
    cyc(1'b1, 1'b0, 2'd0, 8'd0);
    chk("R2", {31'd0, pin_out}, 32'd1);
    // R3: standing equality with cnt_en low is no event (toggle)
    cyc(1'b0, 1'b1, 2'd2, 8'h03);
    cyc(1'b0, 1'b1, 2'd0, m_cnt);
    for (int i = 0; i < 4; i++) begin cyc(1'b0, 1'b0, 2'd0, 8'd0); chk_pin("R3"); end
    cyc(1'b1, 1'b0, 2'd0, 8'd0);
    chk_pin("R2");
    // R4: both compares equal, all selector pairs
    for (int s = 0; s < 16; s++) begin
      cyc(1'b0, 1'b1, 2'd0, m_cnt);
      cyc(1'b0, 1'b1, 2'd1, m_cnt);
      cyc(1'b0, 1'b1, 2'd2, 8'(s));
      cyc(1'b1, 1'b0, 2'd0, 8'd0);
      chk_pin("R4");
    end
    // R1: wrap
    cyc(1'b0, 1'b1, 2'd2, 8'h00);
    while (m_cnt != 8'hFF) cyc(1'b1, 1'b0, 2'd0, 8'd0);
    rd("R1", 2'd3, 8'hFF);
    cyc(1'b1, 1'b0, 2'd0, 8'd0);
    rd("R1", 2'd3, 8'h00);
    chk_pin("R5");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic en, we;
      logic [1:0] a;
      en = ($urandom % 4) != 0;
      we = ($urandom % 8) == 0;
      a  = 2'($urandom);
      ctl = 8'($urandom);
      if (a < 2'd2 && ($urandom % 2) == 1) ctl = m_cnt + 8'($urandom % 4);
      cyc(en, we, a, ctl);
      chk_pin("R2");
      if (i % 16 == 0) rd("R1", 2'd3, m_cnt);
      if (i % 64 == 0) rd("R8", 2'd1, m_cb);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule